// File: doc/BRIEF.md
# Serial Switch-Enable Register with Holding Latch

This block is the logic front end of a bank of independent switch channels. A controller sends one bit per enabled clock on a serial input. The bits move through a chain of stages, one stage per channel. A bank of level-sensitive latch bits sits between the chain and the per-channel active-high enable outputs. While the hold input is low, the latch passes the chain contents straight to the outputs. When hold rises, the latch freezes the pattern. The controller can then shift a new pattern in without disturbing the outputs, and lowers hold to apply it.

A clear input acts on the latch bits without waiting for a clock. It forces every enable off and overrides all other inputs, but it leaves the chain contents as they were. The last stage drives a serial output, so several blocks can be chained into one long register. The shift clock is free-running and qualified by an explicit shift-enable input. An active-low reset empties the chain: its assertion takes effect at once, and its release is synchronised to the clock.

Top module: `swbank_ctrl`

## Requirements
- R1: On a rising clock edge with `shift_en` high, `ser_in` enters stage 0 and every stage k takes the previous value of stage k-1.
- R2: On a rising clock edge with `shift_en` low, all stages keep their value.
- R3: While `hold` is low and `clr` is low, `sw_en[k]` equals stage k and follows it without waiting for a clock.
- R4: While `hold` stays high and `clr` is low, `sw_en` keeps the pattern that was present when `hold` rose, whatever shifting takes place.
- R5: While `clr` is high, `sw_en` is all zero at once, regardless of `hold`, `shift_en` or the clock.
- R6: `clr` does not change the stages. If `clr` is released while `hold` is low, the current stage contents appear on `sw_en`. If it is released while `hold` is high, `sw_en` stays all zero until `hold` falls.
- R7: `ser_out` equals stage N-1 and changes only after a rising edge. After N shifts, the first bit shifted in is at stage N-1 (`sw_en[N-1]`), and the last bit shifted in is at stage 0 (`sw_en[0]`).
- R8: `rst_n` low clears all stages at once. After `rst_n` rises, the chain stays cleared for two further rising edges before shifts take effect.
- R9: A latched 1 turns its channel's `sw_en` bit on (1), and a latched 0 turns it off (0). Each channel depends only on its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Active-low reset of the chain, asynchronous assert and synchronised release |
| shift_en | input | 1 | Clock enable for shifting |
| ser_in | input | 1 | Serial data into stage 0 |
| hold | input | 1 | Low: latch transparent; high: latch holds |
| clr | input | 1 | Asynchronous forced-off for all enables |
| sw_en | output | N_CH | Per-channel active-high switch enables |
| ser_out | output | 1 | Copy of the last stage, for chaining |

## Verification
The clocked checks assume that `hold` and `clr` change away from the rising edge. Inputs are sampled there, so a change exactly at the edge would make the sampled latch state ambiguous. The checks also assume that shifting starts only after the synchronised reset has been released. The stimulus meets both assumptions. It changes every input on the falling edge only, and it leaves `shift_en` low for several cycles after reset. Within those limits, random mixes of shifting, hold and clear are compared against a level-sensitive reference model. Separate directed steps cover the asynchronous effects of clear and reset, which appear between clock edges.

// File: rtl/swbank_pkg.sv
package swbank_pkg;
  localparam int unsigned DEF_CH      = 16;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/swbank_rst_sync.sv
module swbank_rst_sync #(
  parameter int unsigned STAGES = swbank_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/swbank_shift.sv
module swbank_shift #(
  parameter int unsigned N_CH = swbank_pkg::DEF_CH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            din,
  output logic [N_CH-1:0] stage
);
  logic [N_CH-1:0] stage_q;
  logic [N_CH-1:0] stage_d;

  always_comb stage_d = {stage_q[N_CH-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (shift_en) stage_q <= stage_d;
  end

  assign stage = stage_q;

  a_r2_stages_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(stage_q));
  a_r1_din_enters: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> stage_q[0] == $past(din));
endmodule

// File: rtl/swbank_latch.sv
module swbank_latch #(
  parameter int unsigned N_CH = swbank_pkg::DEF_CH
) (
  input  logic            hold,
  input  logic            clr,
  input  logic [N_CH-1:0] d,
  output logic [N_CH-1:0] q
);
  for (genvar g = 0; g < N_CH; g++) begin : g_bit
    logic bit_q;
    always_latch begin
      if (clr)       bit_q = 1'b0;
      else if (!hold) bit_q = d[g];
    end
    assign q[g] = bit_q;
  end
endmodule

// File: rtl/swbank_ctrl.sv
module swbank_ctrl #(
  parameter int unsigned N_CH = swbank_pkg::DEF_CH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            ser_in,
  input  logic            hold,
  input  logic            clr,
  output logic [N_CH-1:0] sw_en,
  output logic            ser_out
);
  localparam int unsigned LAST = N_CH - 1;

  logic            rst_sync_n;
  logic [N_CH-1:0] stage;

  swbank_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  swbank_shift #(.N_CH(N_CH)) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (shift_en),
    .din      (ser_in),
    .stage    (stage)
  );

  swbank_latch #(.N_CH(N_CH)) u_latch (
    .hold (hold),
    .clr  (clr),
    .d    (stage),
    .q    (sw_en)
  );

  assign ser_out = stage[LAST];

  a_r3_transparent: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr && !hold) |-> sw_en == stage);
  a_r4_keep: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hold && $past(hold) && !clr && !$past(clr)) |-> $stable(sw_en));
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr |-> sw_en == '0);
  a_r7_tap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    shift_en |=> ser_out == $past(stage[LAST-1]));
endmodule

// File: tb/swbank_ctrl_tb.sv
module swbank_ctrl_tb;
  localparam int N = 16;

  typedef struct {
    logic [N-1:0] sw;
    logic         so;
    string        req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n, shift_en, ser_in, hold, clr;
  logic [N-1:0] sw_en;
  logic         ser_out;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];
  logic [N-1:0] m_sr, m_q;

  always #4 clk = ~clk;

  swbank_ctrl #(.N_CH(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_in(ser_in),
    .hold(hold), .clr(clr), .sw_en(sw_en), .ser_out(ser_out)
  );

  task automatic check(string req, logic [N-1:0] a_sw, logic a_so,
                       logic [N-1:0] e_sw, logic e_so);
    checks++;
    if (a_sw !== e_sw || a_so !== e_so) begin
      fails++;
      $display("FAIL %s sw_en=%h ser_out=%b expected sw_en=%h ser_out=%b",
               req, a_sw, a_so, e_sw, e_so);
    end
  endtask

  function automatic void latch_eval();
    if (clr)        m_q = '0;
    else if (!hold) m_q = m_sr;
  endfunction

  task automatic step(logic en, logic din, logic h, logic c, string req);
    exp_t e;
    @(negedge clk);
    shift_en = en; ser_in = din; hold = h; clr = c;
    latch_eval();
    if (en) m_sr = {m_sr[N-2:0], din};
    latch_eval();
    e.sw = m_q; e.so = m_sr[N-1]; e.req = req;
    q.push_back(e);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, sw_en, ser_out, e.sw, e.so);
      end
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] pat;
    rst_n = 1'b0; shift_en = 1'b0; ser_in = 1'b0; hold = 1'b0; clr = 1'b0;
    m_sr = '0; m_q = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 check("R8 reset state", sw_en, ser_out, '0, 1'b0);

    // R4: shift a pattern in with hold high, outputs stay put
    pat = 16'hA5C3;
    for (int i = N - 1; i >= 0; i--) step(1'b1, pat[i], 1'b1, 1'b0, "R4 hold while shifting");
    // R7/R9: open latch, first bit sits on channel 15
    step(1'b0, 1'b0, 1'b0, 1'b0, "R7 R9 ordering after open");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R3 transparent idle");
    for (int i = 0; i < 5; i++) step(1'b1, i[0], 1'b0, 1'b0, "R3 transparent shift");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R4 capture on hold rise");
    for (int i = 0; i < 7; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R4 keep");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "R2 no shift");

    // R5: clear acts between edges
    @(negedge clk);
    clr = 1'b1;
    #1 check("R5 async clear", sw_en, ser_out, '0, m_sr[N-1]);
    m_q = '0;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b1, "R5 clear overrides");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R6 release shows stages");
    step(1'b0, 1'b0, 1'b1, 1'b1, "R6 clear while held");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R6 released while held stays off");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R6 hold fall shows stages");

    // random mix against the reference model
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(r[0] | r[3], r[1], ($urandom_range(0, 3) == 0) ? ~hold : hold,
           ($urandom_range(0, 15) == 0), "R1 random");
    end
    step(1'b0, 1'b0, 1'b0, 1'b0, "R1 drain");
    wait (q.size() == 0);

    // R8: asynchronous reset assertion empties the chain
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R8 async reset", sw_en, ser_out, '0, 1'b0);
    m_sr = '0; m_q = '0;
    @(negedge clk);
    rst_n = 1'b1;
    shift_en = 1'b1; ser_in = 1'b1;
    @(negedge clk);
    #1 check("R8 synchronised release", sw_en, ser_out, '0, 1'b0);
    shift_en = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b0, "R8 shift after release");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R9 independent bits");
    wait (q.size() == 0);
    @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule